// File: doc/BRIEF.md
# Message-Signalled Interrupt Flag Bank

This block collects message-signalled interrupts into a bank of flag registers. An agent that wants to raise an interrupt does one write to a shared index register. The written word names a flag register and a bit position, and the block sets that single flag. Each flag register has one interrupt output. The output is high while the register holds at least one set flag and its mask bit allows it.

Software services an interrupt by reading the flag register. The read returns the accumulated flags and clears the whole register in the same access. A separate mask register holds one enable bit per flag register and can be read and written. Read data is registered and appears one cycle after the read strobe. Writes and reads have separate address buses, so a message write and a service read can fall in the same cycle.

Top module: `msi_flag_bank`

## Requirements
- R1: A write to address 9 (the index register) sets bit `wr_data_i[4:0]` of flag register `wr_data_i[7:5]`. The flag is visible from the clock edge that takes the write.
- R2: An index write changes exactly one flag in exactly one register. All other flags in all registers keep their values.
- R3: Flags accumulate until their register is read. Writing the index for a flag that is already set changes nothing.
- R4: A read of address k (0 to 7) puts the contents of flag register k on `rd_data_o` after the next clock edge and clears every flag of register k at that edge.
- R5: `irq_o[k]` is high exactly when flag register k has any flag set and mask bit k is 0.
- R6: Address 8 is the mask register. Bit k masks register k (1 = masked, 0 = enabled). It is written by a bus write and read back through `rd_data_o`.
- R7: After reset all flags are 0, every mask bit is 1, `irq_o` is 0 and `rd_data_o` is 0.
- R8: When an index write and a read of the same flag register share a cycle, the read returns the value before the write. The newly set flag remains set after the clear.
- R9: Writes to flag register addresses 0 to 7 are ignored. A read of the index address returns 0 and clears no flag.
- R10: In an index write, bits `wr_data_i[31:8]` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 32 | Registered read data, valid the cycle after `rd_en_i` |
| irq_o | output | 8 | Interrupt output, one per flag register |

## Verification
The assertions check on every cycle that:
- an index write sets its target flag;
- an index write decodes to at most one flag in the whole bank;
- an unaccessed register holds its flags;
- a read with no concurrent set leaves the register empty;
- a masked register never drives its interrupt.

Only the bench's scenarios can show the following, because they depend on the data returned across a sequence of accesses:
- the value returned by a read;
- the old-value result when a write and a read of the same register collide;
- reset state of the mask register;
- the register map, including ignored writes and non-clearing reads of the index address.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  typedef enum logic [1:0] {
    ACC_FLAG  = 2'd0,
    ACC_MASK  = 2'd1,
    ACC_INDEX = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e classify_addr(input int unsigned addr, input int unsigned num_regs);
    if (addr < num_regs)           return ACC_FLAG;
    else if (addr == num_regs)     return ACC_MASK;
    else if (addr == num_regs + 1) return ACC_INDEX;
    else                           return ACC_NONE;
  endfunction

endpackage

// File: rtl/msi_index_decode.sv
module msi_index_decode #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned FLAG_W   = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             idx_we_i,
  input  logic [DATA_W-1:0]                idx_data_i,
  output logic [NUM_REGS-1:0][FLAG_W-1:0]  set_o
);
  localparam int unsigned BIT_W = $clog2(FLAG_W);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic [SEL_W-1:0] reg_sel;
  logic [BIT_W-1:0] bit_sel;
  logic [FLAG_W-1:0] bit_vec;

  // only the low select fields matter; upper data bits are dropped
  assign bit_sel = idx_data_i[BIT_W-1:0];
  assign reg_sel = idx_data_i[BIT_W +: SEL_W];
  assign bit_vec = FLAG_W'(1) << bit_sel;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign set_o[r] = (idx_we_i && reg_sel == SEL_W'(r)) ? bit_vec : '0;
  end

  p_single_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_o) <= 1)
    else $error("index decode set more than one flag");

  p_write_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i && (reg_sel < NUM_REGS) |-> $countones(set_o) == 1)
    else $error("index write produced no set");

endmodule

// File: rtl/msi_flag_reg.sv
module msi_flag_reg #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clr_i,
  input  logic              mask_we_i,
  input  logic              mask_d_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              mask_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q;
  logic              mask_q;

  // clear takes old contents away, a same-cycle set survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= 1'b1;
    end else begin
      flags_q <= (clr_i ? '0 : flags_q) | set_i;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = (|flags_q) & ~mask_q;

  p_set_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> (flags_q & $past(set_i)) == $past(set_i))
    else $error("set flag missing");

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && set_i == '0 |=> $stable(flags_q))
    else $error("flags changed without access");

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && set_i == '0 |=> flags_q == '0)
    else $error("read did not clear");

endmodule

// File: rtl/msi_read_port.sv
module msi_read_port #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned FLAG_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_en_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  input  logic [NUM_REGS-1:0][FLAG_W-1:0]  flags_i,
  input  logic [NUM_REGS-1:0]              mask_i,
  output logic [NUM_REGS-1:0]              clr_o,
  output logic [DATA_W-1:0]                rd_data_o
);
  import msi_bank_pkg::*;

  acc_kind_e   rd_kind;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_data_q;

  assign rd_kind = classify_addr(int'(rd_addr_i), NUM_REGS);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_clr
    assign clr_o[r] = rd_en_i && rd_addr_i == ADDR_W'(r);
  end

  always_comb begin
    rd_mux = '0;
    unique case (rd_kind)
      ACC_FLAG: begin
        for (int r = 0; r < NUM_REGS; r++)
          if (clr_o[r]) rd_mux = DATA_W'(flags_i[r]);
      end
      ACC_MASK:  rd_mux = DATA_W'(mask_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_mux;
  end

  assign rd_data_o = rd_data_q;

  p_one_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o))
    else $error("more than one register cleared");

  p_idx_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == ADDR_W'(NUM_REGS + 1) |=> rd_data_o == '0)
    else $error("index read returned data");

endmodule

// File: rtl/msi_flag_bank.sv
module msi_flag_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned FLAG_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [NUM_REGS-1:0] irq_o
);
  import msi_bank_pkg::*;

  acc_kind_e wr_kind;
  logic      idx_we;
  logic      mask_we;

  logic [NUM_REGS-1:0][FLAG_W-1:0] set_vec;
  logic [NUM_REGS-1:0][FLAG_W-1:0] flags;
  logic [NUM_REGS-1:0]             mask;
  logic [NUM_REGS-1:0]             clr;

  assign wr_kind = classify_addr(int'(wr_addr_i), NUM_REGS);
  assign idx_we  = wr_en_i && wr_kind == ACC_INDEX;
  assign mask_we = wr_en_i && wr_kind == ACC_MASK;

  msi_index_decode #(
    .NUM_REGS (NUM_REGS),
    .FLAG_W   (FLAG_W),
    .DATA_W   (DATA_W)
  ) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_we_i   (idx_we),
    .idx_data_i (wr_data_i),
    .set_o      (set_vec)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    msi_flag_reg #(
      .FLAG_W (FLAG_W)
    ) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_vec[r]),
      .clr_i     (clr[r]),
      .mask_we_i (mask_we),
      .mask_d_i  (wr_data_i[r]),
      .flags_o   (flags[r]),
      .mask_o    (mask[r]),
      .irq_o     (irq_o[r])
    );

    p_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask[r] |-> !irq_o[r])
      else $error("masked register raised interrupt");

    p_empty_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags[r] == '0 |-> !irq_o[r])
      else $error("empty register raised interrupt");
  end

  msi_read_port #(
    .NUM_REGS (NUM_REGS),
    .FLAG_W   (FLAG_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .flags_i   (flags),
    .mask_i    (mask),
    .clr_o     (clr),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: tb/msi_flag_bank_test.sv
`timescale 1ns/1ps
module msi_flag_bank_test;
  localparam int NR = 8;
  localparam logic [3:0] A_MASK = 4'd8;
  localparam logic [3:0] A_IDX  = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msi_flag_bank uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled 1 ns after the edge
  task automatic cyc(input bit we, input logic [3:0] wa, input logic [31:0] wd,
                     input bit re, input logic [3:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(1'b0, '0, '0, 1'b1, a);
  endtask

  function automatic logic [31:0] idx(input int r, input int b);
    return 32'((r << 5) | b);
  endfunction

  task automatic t_reset();
    check("R7 irq", 32'(irq), 32'h0);
    check("R7 rdata", rd_data, 32'h0);
    rd(A_MASK);
    check("R7 mask", rd_data, 32'hFF);
    for (int r = 0; r < NR; r++) begin
      rd(4'(r));
      check("R7 flags", rd_data, 32'h0);
    end
  endtask

  task automatic t_set_read();
    wr(A_MASK, 32'h0);
    rd(A_MASK);
    check("R6 mask rw", rd_data, 32'h0);
    wr(A_IDX, idx(3, 17));
    check("R1 R5 irq", 32'(irq), 32'h08);
    rd(4'd3);
    check("R4 read", rd_data, 32'h0002_0000);
    check("R4 R5 irq cleared", 32'(irq), 32'h0);
    rd(4'd3);
    check("R4 cleared", rd_data, 32'h0);
  endtask

  task automatic t_accum();
    wr(A_IDX, idx(5, 0));
    wr(A_IDX, idx(5, 31));
    wr(A_IDX, idx(5, 0));
    rd(4'd5);
    check("R3 accumulate", rd_data, 32'h8000_0001);
  endtask

  task automatic t_isolate();
    wr(A_IDX, idx(0, 4));
    check("R2 irq only r0", 32'(irq), 32'h01);
    for (int r = 1; r < NR; r++) begin
      rd(4'(r));
      check("R2 others", rd_data, 32'h0);
    end
    rd(4'd0);
    check("R2 target", rd_data, 32'h10);
  endtask

  task automatic t_mask();
    wr(A_MASK, 32'h04);
    wr(A_IDX, idx(2, 7));
    check("R5 masked", 32'(irq), 32'h0);
    rd(A_MASK);
    check("R6 mask read", rd_data, 32'h04);
    wr(A_MASK, 32'h00);
    check("R5 unmasked", 32'(irq), 32'h04);
    rd(4'd2);
    check("R5 flag kept", rd_data, 32'h80);
  endtask

  task automatic t_collide();
    wr(A_IDX, idx(6, 1));
    cyc(1'b1, A_IDX, idx(6, 9), 1'b1, 4'd6);
    check("R8 old value", rd_data, 32'h2);
    check("R8 irq", 32'(irq), 32'h40);
    rd(4'd6);
    check("R8 new bit kept", rd_data, 32'h200);
  endtask

  task automatic t_ignore();
    wr(4'd4, 32'hFFFF_FFFF);
    check("R9 write ignored irq", 32'(irq), 32'h0);
    rd(4'd4);
    check("R9 write ignored", rd_data, 32'h0);
    wr(A_IDX, idx(1, 2));
    rd(A_IDX);
    check("R9 index read", rd_data, 32'h0);
    rd(4'd1);
    check("R9 no clear", rd_data, 32'h4);
    wr(A_IDX, 32'hFFFF_FF00 | idx(7, 3));
    check("R10 irq", 32'(irq), 32'h80);
    rd(4'd7);
    check("R10 upper ignored", rd_data, 32'h8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1;
    check("R7 rdata in reset", rd_data, 32'h0);
    #10 rst_n = 1'b1;
    t_reset();
    t_set_read();
    t_accum();
    t_isolate();
    t_mask();
    t_collide();
    t_ignore();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule